// File: doc/BRIEF.md
# Management Data Frame Master

This block runs complete register transactions against an Ethernet PHY over a two-wire management link made of a clock line (MDC) and a bidirectional data line (MDIO). A host asserts a request with a read/write flag, a PHY address, a register address and, for writes, a data word. The controller then builds the whole frame in hardware and drives MDIO through a separate output, output-enable and input, so it can sit behind a tri-state pad. The frame consists of a preamble, a command header, a turnaround and the data field. For reads it returns the captured word together with an error flag. A one-cycle done pulse marks the end of every frame.

MDC is produced by counting system clocks: each MDC half-period lasts `HALF_DIV` cycles. Outgoing bits change only while MDC is low, so the PHY captures them on the rising edge. Incoming bits are sampled on the system-clock edge that raises MDC, which is the last moment of the low phase. The design is one state machine with six states. `S_IDLE` waits for a request. `S_PRE` sends the preamble. `S_CMD` shifts out the header. For a write, `S_WDAT` shifts out the turnaround pattern and the data. For a read, `S_TURN` hands the line to the PHY and `S_RDAT` samples the error slot and the data bits. The transitions are: IDLE→PRE when a request is accepted; PRE→CMD after the last preamble cycle; CMD→WDAT or CMD→TURN after the last header bit, chosen by the latched read/write flag; TURN→RDAT after one MDC cycle; WDAT→IDLE and RDAT→IDLE on the falling MDC edge that ends the last bit.

Top module: `mdio_master`

## Requirements
- R1: Each frame begins with 32 MDC cycles during which mdio_oe=1 and mdio_o=1.
- R2: After the preamble, 14 header bits are sent most significant first: start code 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register address.
- R3: mdio_o and mdio_oe never change while MDC is high, so every driven bit is stable across the rising MDC edge.
- R4: A write frame follows the header with turnaround pattern 10 and then the 16 data bits, most significant first. This gives 64 MDC cycles in total, with mdio_oe=1 at every rising edge.
- R5: A read frame deasserts mdio_oe with no MDC edge right after the header. It then runs one turnaround cycle, one error-sample cycle and 16 data cycles (64 MDC cycles in total), and mdio_oe stays 0 at each of the last 18 rising edges.
- R6: In a read, the level of mdio_i sampled at the rise of MDC cycle 47 (counting from 0) is the error flag. When it is 1, rd_err=1 and rd_data is all zeros, whatever the PHY drove afterwards.
- R7: When the error sample is 0, rd_err=0 and rd_data holds the mdio_i levels sampled at the rises of MDC cycles 48 to 63, the first sample being the most significant bit.
- R8: Each MDC low phase and high phase lasts HALF_DIV system clock cycles, and MDC stays low whenever busy=0.
- R9: busy=1 from the cycle after a request is accepted until the frame ends. A request is accepted only while busy=0, and a request presented while busy=1 has no effect on the frame or on later activity.
- R10: done is a single-cycle pulse, raised in the cycle when busy falls. rd_data and rd_err are valid from that cycle on.
- R11: Whenever busy=0 the master drives the line (mdio_oe=1) at the idle level mdio_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy=0 |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Read result (zero on error) |
| rd_err | output | 1 | PHY did not answer the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |
| mdio_i | input | 1 | Level seen on MDIO |

## Verification
The bench builds the block with HALF_DIV=3. With that value every low and high phase is three cycles long and can be counted exactly, and a 64-cycle frame completes in a few hundred system clocks, so each scenario in the bench gets a full frame. An odd divider also means the sampling edge and the driving edge never coincide with a half-way point by accident. A bench-side PHY model answers reads slot by slot, or leaves the line pulled high to imitate an absent PHY, and this exercises the forced-zero path.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_CMD,
        S_WDAT,
        S_TURN,
        S_RDAT
    } mdio_state_t;

    localparam logic [1:0] CODE_START = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] WR_TURN    = 2'b10;

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take_err,
    input  logic              take_bit,
    input  logic              din,
    output logic [DATA_W-1:0] data,
    output logic              err
);
    logic [DATA_W-1:0] shreg;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            err_q <= 1'b0;
        end else begin
            if (take_err) begin
                err_q <= din;
            end
            if (take_bit) begin
                shreg <= {shreg[DATA_W-2:0], din};
            end
        end
    end

    assign err  = err_q;
    assign data = err_q ? '0 : shreg;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 10,
    parameter int PHY_W    = 5,
    parameter int REG_W    = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int HDR_BITS  = 4 + PHY_W + REG_W;
    localparam int WR_SLOTS  = 2 + DATA_W;
    localparam int RD_SLOTS  = 1 + DATA_W;
    localparam int TX_W      = HDR_BITS + WR_SLOTS;
    localparam int MAX_CNT   = (PRE_LEN > WR_SLOTS) ? PRE_LEN : WR_SLOTS;
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    mdio_state_t       state, state_nxt;
    logic [TX_W-1:0]   tx_sr;
    logic [CNT_W-1:0]  cnt;
    logic              mdc_q;
    logic              done_q;
    logic              wr_q;
    logic              tick;
    logic              rise_ev;
    logic              fall_ev;
    logic              accept;

    mdio_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != S_IDLE),
        .tick  (tick)
    );

    assign rise_ev = tick && !mdc_q;
    assign fall_ev = tick && mdc_q;
    assign accept  = (state == S_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (req_valid) state_nxt = S_PRE;
            S_PRE:  if (fall_ev && cnt == CNT_W'(PRE_LEN - 1)) state_nxt = S_CMD;
            S_CMD:  if (fall_ev && cnt == CNT_W'(HDR_BITS - 1))
                        state_nxt = wr_q ? S_WDAT : S_TURN;
            S_WDAT: if (fall_ev && cnt == CNT_W'(WR_SLOTS - 1)) state_nxt = S_IDLE;
            S_TURN: if (fall_ev) state_nxt = S_RDAT;
            S_RDAT: if (fall_ev && cnt == CNT_W'(RD_SLOTS - 1)) state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Frame datapath: bit counter, transmit shifter, clock line, done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tx_sr  <= '0;
            mdc_q  <= 1'b0;
            done_q <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            done_q <= fall_ev && (state_nxt == S_IDLE);
            if (state == S_IDLE) begin
                mdc_q <= 1'b0;
            end else if (tick) begin
                mdc_q <= ~mdc_q;
            end
            if (state_nxt != state) begin
                cnt <= '0;
            end else if (fall_ev) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (accept) begin
                wr_q  <= req_write;
                tx_sr <= {CODE_START, (req_write ? OP_WRITE : OP_READ),
                          req_phy, req_reg, WR_TURN, req_wdata};
            end else if (fall_ev && (state == S_CMD || state == S_WDAT)) begin
                tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
            end
        end
    end

    mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .take_err (rise_ev && state == S_RDAT && cnt == '0),
        .take_bit (rise_ev && state == S_RDAT && cnt != '0),
        .din      (mdio_i),
        .data     (rd_data),
        .err      (rd_err)
    );

    // Outputs
    always_comb begin
        mdio_oe = 1'b1;
        mdio_o  = 1'b1;
        unique case (state)
            S_CMD, S_WDAT: mdio_o = tx_sr[TX_W-1];
            S_TURN, S_RDAT: mdio_oe = 1'b0;
            default: mdio_o = 1'b1;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = done_q;
    assign mdc  = mdc_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_err
);
    // R3: data held across the whole high phase
    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R5: direction changes only with MDC low
    assert_dir_edge_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc);

    // R6: error forces zero data
    assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_err) |-> (rd_data == '0));

    // R8: clock parked low while idle
    assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R10: single-cycle done, coincident with idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: master owns the line at idle level
    assert_idle_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdio_oe && mdio_o));
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_data (rd_data),
    .rd_err  (rd_err)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, rd_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // PHY model controls
    logic        phy_present = 1'b1;
    logic [15:0] phy_data = '0;

    // Monitor state
    logic [63:0] obs_o;
    logic [63:0] obs_oe;
    int          rises = 0;
    int          lo_len = 0;
    int          hi_len = 0;
    int          per_err = 0;
    logic        prev_mdc = 1'b0;
    logic        prev_busy = 1'b0;

    always #2 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                rises = 0;
                lo_len = 0;
                hi_len = 0;
                obs_o = '0;
                obs_oe = '0;
            end
            if (mdc && !prev_mdc) begin
                obs_o  = {obs_o[62:0], mdio_o};
                obs_oe = {obs_oe[62:0], mdio_oe};
                rises++;
                if (lo_len != HALF) per_err++;
                lo_len = 0;
                hi_len = 1;
            end else if (!mdc && prev_mdc) begin
                if (hi_len != HALF) per_err++;
                hi_len = 0;
                lo_len = busy ? 1 : 0;
            end else if (busy) begin
                if (mdc) hi_len++;
                else     lo_len++;
            end
            if (!phy_present)                 mdio_i = 1'b1;
            else if (rises == 47)             mdio_i = 1'b0;
            else if (rises >= 48 && rises <= 63) mdio_i = phy_data[63 - rises];
            else                              mdio_i = 1'b1;
        end
        prev_mdc  = mdc;
        prev_busy = busy;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request and wait for its end; checks busy and the done pulse.
    task automatic run_frame(input logic wr, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd);
        bit seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", 64'(busy), 64'd1);
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk("R10 done seen", 64'(seen), 64'd1);
        chk("R10 busy low with done", 64'(busy), 64'd0);
    endtask

    task automatic post_frame_checks();
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 64'd0);
        chk("R8 mdc low at idle", 64'(mdc), 64'd0);
        chk("R11 idle drive", {62'd0, mdio_oe, mdio_o}, 64'd3);
        chk("R8 half period length", 64'(per_err), 64'd0);
    endtask

    task automatic t_reset();
        chk("R9 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R8 reset mdc", 64'(mdc), 64'd0);
        chk("R11 reset drive", {62'd0, mdio_oe, mdio_o}, 64'd3);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, wd};
        run_frame(1'b1, phy, rg, wd);
        chk("R4 write cycle count", 64'(rises), 64'd64);
        chk("R1 preamble", {32'd0, obs_o[63:32]}, 64'hFFFF_FFFF);
        chk("R2 write header", 64'(obs_o[31:18]), 64'({2'b01, 2'b01, phy, rg}));
        chk("R4 write turnaround and data", 64'(obs_o[17:0]), 64'({2'b10, wd}));
        chk("R4 write frame", obs_o, exp);
        chk("R4 write drive enable", obs_oe, {64{1'b1}});
        post_frame_checks();
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] pd, input logic present);
        phy_present = present;
        phy_data = pd;
        run_frame(1'b0, phy, rg, 16'h0);
        chk("R5 read cycle count", 64'(rises), 64'd64);
        chk("R1 preamble", {32'd0, obs_o[63:32]}, 64'hFFFF_FFFF);
        chk("R2 read header", 64'(obs_o[31:18]), 64'({2'b01, 2'b10, phy, rg}));
        chk("R5 read drive enable", obs_oe, {{46{1'b1}}, 18'd0});
        if (present) begin
            chk("R7 read error flag", 64'(rd_err), 64'd0);
            chk("R7 read data", 64'(rd_data), 64'(pd));
        end else begin
            chk("R6 error flag", 64'(rd_err), 64'd1);
            chk("R6 forced zero data", 64'(rd_data), 64'd0);
        end
        post_frame_checks();
        phy_present = 1'b1;
    endtask

    task automatic t_busy_ignore();
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h5AA5};
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h0A; req_reg = 5'h15;
        req_wdata = 16'h5AA5;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h1F; req_reg = 5'h00;
        req_wdata = 16'hFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        chk("R9 frame unaffected by busy request", obs_o, exp);
        repeat (20) @(negedge clk);
        chk("R9 no deferred frame", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(5'h01, 5'h00, 16'h8001);
        t_write(5'h1E, 5'h1B, 16'h3C69);
        t_read(5'h03, 5'h02, 16'hC35A, 1'b1);
        t_read(5'h10, 5'h1F, 16'h0001, 1'b1);
        t_read(5'h07, 5'h05, 16'hFFFF, 1'b0);
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule